// File: doc/BRIEF.md
# Segment Base-Limit Translation Unit

The unit turns a logical address, given as a segment number and an offset, into a physical address. A request also carries an access type: read, write or execute. The segment number is first compared with a segment-count input. When it is in range, the unit reads one 64-bit descriptor from a table in memory. The table's location comes from a table-base input, and each descriptor takes eight bytes.

The descriptor holds the segment's physical base, its length limit, a validity bit and three permission bits. The unit checks the offset against the limit and the access type against the permission bits. It then returns either base plus offset or a fault code.

The unit handles one request at a time. A segment number that is out of range is answered without any memory traffic. For a legal segment number the unit issues a single table read and waits, for as many cycles as memory needs, for the response.

Top module: `seg_xlate`

## Requirements
- R1: While reset is low and after it is released, `res_valid_o` and `mem_req_o` are 0 and `req_ready_o` is 1.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. If the segment number is not less than `seg_count_i`, `res_valid_o` is 1 in the next cycle with fault code 1 (range), and no table read is issued.
- R3: A request with a legal segment number raises `mem_req_o` for exactly one cycle, in the cycle after acceptance, with `mem_addr_o` = `tbl_base_i` + 8 × segment number. `req_ready_o` stays 0 from then until the result is delivered.
- R4: Descriptor layout in `mem_rdata_i`: base is bits 31:0, limit is bits 51:32, valid is bit 52, read permission is bit 53, write permission is bit 54 and execute permission is bit 55. Bits 63:56 are ignored.
- R5: A descriptor with a valid bit of 0 gives fault code 2 (invalid segment).
- R6: An offset greater than or equal to the limit gives fault code 3 (limit). A limit of 0 therefore faults every offset.
- R7: The access type is encoded as 0 read, 1 write, 2 execute. An access whose permission bit is 0 gives fault code 4 (permission). Access type 3 always gives fault code 4.
- R8: Fault priority is range, then invalid, then limit, then permission. Code 0 means no fault.
- R9: For a table read, the result appears in the cycle after the edge that takes `mem_rvalid_i`. A fault-free result gives `res_addr_o` = (base + offset) mod 2^32. Any fault drives `res_addr_o` to 0.
- R10: `mem_rvalid_i` is ignored when no table read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Unit can accept a request |
| req_seg_i | input | SEG_W | Segment number |
| req_off_i | input | OFF_W | Offset within the segment |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| tbl_base_i | input | AW | Byte address of descriptor 0 |
| seg_count_i | input | SEG_W+1 | Number of legal segments |
| mem_req_o | output | 1 | Table read strobe, one cycle |
| mem_addr_o | output | AW | Descriptor byte address |
| mem_rvalid_i | input | 1 | Table read data valid |
| mem_rdata_i | input | 64 | Descriptor data |
| res_valid_o | output | 1 | Result strobe, one cycle |
| res_addr_o | output | PA_W | Physical address, 0 on a fault |
| res_fault_o | output | 3 | Fault code (see R8) |

## Verification
A range fault is due one cycle after acceptance. A table read strobe is also due one cycle after acceptance. A descriptor-based result is due one cycle after the edge that samples `mem_rvalid_i`, whatever memory latency of one to three cycles the bench's responder applies.

The bench's reference model advances on the same rising edges from the same sampled inputs. Every falling edge then compares ready, strobe, address and fault against the model, so an early or late result fails in the cycle where it differs. Spurious response strobes and requests held high across a busy period test the timing where acceptance and response edges could be miscounted.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ENT_W  = 64;
  localparam int BASE_W = 32;
  localparam int LIM_W  = 20;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  // packed MSB-first: x=55 w=54 r=53 v=52 lim=51:32 base=31:0
  typedef struct packed {
    logic              x;
    logic              w;
    logic              r;
    logic              v;
    logic [LIM_W-1:0]  lim;
    logic [BASE_W-1:0] base;
  } seg_ent_t;

  localparam int ENT_USED = $bits(seg_ent_t);
endpackage

// File: rtl/seg_range_chk.sv
module seg_range_chk #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [SEG_W:0]   cnt_i,
  output logic             ok_o
);
  assign ok_o = ({1'b0, seg_i} < cnt_i);
endmodule

// File: rtl/seg_tbl_addr.sv
module seg_tbl_addr #(
  parameter int SEG_W     = 8,
  parameter int AW        = 32,
  parameter int ENT_BYTES = 8
) (
  input  logic [AW-1:0]    base_i,
  input  logic [SEG_W-1:0] seg_i,
  output logic [AW-1:0]    addr_o
);
  localparam int SH = $clog2(ENT_BYTES);
  assign addr_o = base_i + (AW'(seg_i) << SH);
endmodule

// File: rtl/seg_entry_chk.sv
module seg_entry_chk import seg_xlate_pkg::*; #(
  parameter int OFF_W = 20,
  parameter int PA_W  = 32
) (
  input  logic [ENT_W-1:0] ent_i,
  input  logic [OFF_W-1:0] off_i,
  input  acc_e             acc_i,
  output fault_e           fault_o,
  output logic [PA_W-1:0]  pa_o
);
  localparam int CMP_W = (OFF_W > LIM_W) ? OFF_W : LIM_W;

  seg_ent_t   ent;
  logic [2:0] perm_bits;
  logic [2:0] acc_hit;
  logic       perm_ok;
  logic       over_lim;
  logic       spare_unused;

  assign ent          = seg_ent_t'(ent_i[ENT_USED-1:0]);
  assign spare_unused = ^ent_i[ENT_W-1:ENT_USED];
  assign perm_bits    = {ent.x, ent.w, ent.r};

  // one hit term per encoded access type; type 3 has none
  generate
    for (genvar i = 0; i < 3; i++) begin : g_perm
      assign acc_hit[i] = (acc_i == acc_e'(2'(i))) && perm_bits[i];
    end
  endgenerate

  assign perm_ok  = |acc_hit;
  assign over_lim = CMP_W'(off_i) >= CMP_W'(ent.lim);
  assign pa_o     = PA_W'(ent.base) + PA_W'(off_i);

  always_comb begin
    if (!ent.v)        fault_o = FLT_INVALID;
    else if (over_lim) fault_o = FLT_LIMIT;
    else if (!perm_ok) fault_o = FLT_PERM;
    else               fault_o = FLT_NONE;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate import seg_xlate_pkg::*; #(
  parameter int SEG_W = 8,
  parameter int OFF_W = 20,
  parameter int PA_W  = 32,
  parameter int AW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [1:0]       req_acc_i,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic [SEG_W:0]   seg_count_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [ENT_W-1:0] mem_rdata_i,
  output logic             res_valid_o,
  output logic [PA_W-1:0]  res_addr_o,
  output logic [2:0]       res_fault_o
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e           state_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;
  logic             mem_req_q;
  logic [AW-1:0]    mem_addr_q;
  logic             res_valid_q;
  logic [PA_W-1:0]  res_addr_q;
  fault_e           res_fault_q;

  logic             seg_ok;
  logic [AW-1:0]    tbl_addr;
  fault_e           ent_fault;
  logic [PA_W-1:0]  ent_pa;

  seg_range_chk #(.SEG_W(SEG_W)) u_range (
    .seg_i (req_seg_i),
    .cnt_i (seg_count_i),
    .ok_o  (seg_ok)
  );

  seg_tbl_addr #(.SEG_W(SEG_W), .AW(AW), .ENT_BYTES(ENT_W / 8)) u_addr (
    .base_i (tbl_base_i),
    .seg_i  (req_seg_i),
    .addr_o (tbl_addr)
  );

  seg_entry_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_ent (
    .ent_i   (mem_rdata_i),
    .off_i   (off_q),
    .acc_i   (acc_e'(acc_q)),
    .fault_o (ent_fault),
    .pa_o    (ent_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      off_q       <= '0;
      acc_q       <= '0;
      mem_req_q   <= 1'b0;
      mem_addr_q  <= '0;
      res_valid_q <= 1'b0;
      res_addr_q  <= '0;
      res_fault_q <= FLT_NONE;
    end else begin
      mem_req_q   <= 1'b0;
      res_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            off_q <= req_off_i;
            acc_q <= req_acc_i;
            if (seg_ok) begin
              mem_req_q  <= 1'b1;
              mem_addr_q <= tbl_addr;
              state_q    <= ST_WAIT;
            end else begin
              // out-of-range segment: answer without a table read
              res_valid_q <= 1'b1;
              res_fault_q <= FLT_RANGE;
              res_addr_q  <= '0;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            res_valid_q <= 1'b1;
            res_fault_q <= ent_fault;
            res_addr_q  <= (ent_fault == FLT_NONE) ? ent_pa : '0;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = mem_req_q;
  assign mem_addr_o  = mem_addr_q;
  assign res_valid_o = res_valid_q;
  assign res_addr_o  = res_addr_q;
  assign res_fault_o = res_fault_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 8,
  parameter int PA_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [SEG_W-1:0] req_seg_i,
  input logic [SEG_W:0]   seg_count_i,
  input logic             mem_req_o,
  input logic             res_valid_o,
  input logic [PA_W-1:0]  res_addr_o,
  input logic [2:0]       res_fault_o
);
  logic acc_q_in;
  logic in_rng;
  assign acc_q_in = req_valid_i && req_ready_o;
  assign in_rng   = ({1'b0, req_seg_i} < seg_count_i);

  assert_range_fault_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q_in && !in_rng) |=> (res_valid_o && res_fault_o == 3'd1 && !mem_req_o));

  assert_tbl_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q_in && in_rng) |=> (mem_req_o && !res_valid_o && !req_ready_o));

  assert_read_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  assert_fault_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o != 3'd0) |-> (res_addr_o == '0));

  assert_fault_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_fault_o <= 3'd4));

  assert_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, res_valid_o}));
endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (.*);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  localparam int SEG_W = 8;
  localparam int OFF_W = 20;
  localparam int PA_W  = 32;
  localparam int AW    = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [SEG_W-1:0] req_seg_i = '0;
  logic [OFF_W-1:0] req_off_i = '0;
  logic [1:0]       req_acc_i = '0;
  logic [AW-1:0]    tbl_base_i = 32'h0000_1000;
  logic [SEG_W:0]   seg_count_i = 9'd12;
  logic             mem_req_o;
  logic [AW-1:0]    mem_addr_o;
  logic             mem_rvalid_i = 1'b0;
  logic [63:0]      mem_rdata_i = '0;
  logic             res_valid_o;
  logic [PA_W-1:0]  res_addr_o;
  logic [2:0]       res_fault_o;

  always #5 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_seg_i(req_seg_i), .req_off_i(req_off_i), .req_acc_i(req_acc_i),
    .tbl_base_i(tbl_base_i), .seg_count_i(seg_count_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .res_valid_o(res_valid_o), .res_addr_o(res_addr_o), .res_fault_o(res_fault_o)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    done    = 1'b0;
  string cur_tag = "R1";
  int    lat     = 1;
  bit    spur    = 1'b0;
  logic [63:0] ent [16];

  task automatic chk(bit ok, string what, longint got, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s got %0h exp %0h", cur_tag, what, got, exp);
    end
  endtask

  // R4 layout: x=55 w=54 r=53 v=52 lim=51:32 base=31:0, top byte junk
  function automatic logic [63:0] mk(logic [31:0] b, logic [19:0] l,
                                     bit v, bit r, bit w, bit x);
    return {8'hA5, x, w, r, v, l, b};
  endfunction

  function automatic logic [63:0] lookup(logic [31:0] a);
    logic [31:0] d;
    d = a - tbl_base_i;
    if (d[2:0] == 3'd0 && (d >> 3) < 16) return ent[int'(d >> 3)];
    return 64'h0;
  endfunction

  function automatic int ref_fault(logic [63:0] e, logic [19:0] off, int acc);
    bit ok;
    if (!e[52]) return 2;
    if (off >= e[51:32]) return 3;
    case (acc)
      0: ok = e[53];
      1: ok = e[54];
      2: ok = e[55];
      default: ok = 1'b0;
    endcase
    return ok ? 0 : 4;
  endfunction

  // reference model
  int          m_state = 0;
  bit          m_mem_req = 1'b0;
  bit          m_res_valid = 1'b0;
  logic [31:0] m_mem_addr = '0;
  logic [31:0] m_res_addr = '0;
  int          m_fault = 0;
  logic [19:0] m_off = '0;
  int          m_acc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_mem_req <= 1'b0; m_res_valid <= 1'b0;
    end else begin
      m_mem_req   <= 1'b0;
      m_res_valid <= 1'b0;
      if (m_state == 0 && req_valid_i) begin
        m_off <= req_off_i;
        m_acc <= int'(req_acc_i);
        if (int'(req_seg_i) >= int'(seg_count_i)) begin
          m_res_valid <= 1'b1; m_fault <= 1; m_res_addr <= '0;
        end else begin
          m_mem_req  <= 1'b1;
          m_mem_addr <= tbl_base_i + 32'(req_seg_i) * 8;
          m_state    <= 1;
        end
      end else if (m_state == 1 && mem_rvalid_i) begin
        m_res_valid <= 1'b1;
        m_fault     <= ref_fault(mem_rdata_i, m_off, m_acc);
        m_res_addr  <= (ref_fault(mem_rdata_i, m_off, m_acc) == 0) ?
                       mem_rdata_i[31:0] + 32'(m_off) : 32'h0;
        m_state     <= 0;
      end
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready_o == (m_state == 0), "req_ready_o", req_ready_o, m_state == 0);
      chk(mem_req_o == m_mem_req, "mem_req_o", mem_req_o, m_mem_req);
      if (m_mem_req) chk(mem_addr_o == m_mem_addr, "mem_addr_o", mem_addr_o, m_mem_addr);
      chk(res_valid_o == m_res_valid, "res_valid_o", res_valid_o, m_res_valid);
      if (m_res_valid) begin
        chk(int'(res_fault_o) == m_fault, "res_fault_o", res_fault_o, m_fault);
        chk(res_addr_o == m_res_addr, "res_addr_o", res_addr_o, m_res_addr);
      end
    end
  end

  // table memory with variable latency
  int          pend = 0;
  logic [31:0] paddr = '0;
  always @(negedge clk) begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = {$urandom, $urandom};
    if (mem_req_o) begin
      pend  = lat;
      paddr = mem_addr_o;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = lookup(paddr);
      end
    end else if (spur) begin
      mem_rvalid_i = 1'b1;
      spur = 1'b0;
    end
  end

  task automatic send(string tag, int seg, int off, int acc, int hold, int l);
    cur_tag = tag;
    lat     = l;
    @(negedge clk);
    req_seg_i   = SEG_W'(seg);
    req_off_i   = OFF_W'(off);
    req_acc_i   = 2'(acc);
    req_valid_i = 1'b1;
    repeat (hold) @(negedge clk);
    req_valid_i = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL %s watchdog got %0d cycles exp below 50000", cur_tag, cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) ent[i] = 64'h0;
    ent[0]  = mk(32'h8000_0000, 20'h01000, 1, 1, 1, 1);
    ent[1]  = mk(32'h0010_0000, 20'h00100, 1, 1, 0, 0);
    ent[2]  = mk(32'h0020_0000, 20'h00040, 1, 0, 0, 1);
    ent[3]  = mk(32'h0099_0000, 20'h00010, 0, 1, 1, 1);
    ent[4]  = mk(32'h0030_0000, 20'h00000, 1, 1, 1, 1);
    ent[5]  = mk(32'hFFFF_FFF0, 20'hFFFFF, 1, 1, 1, 0);
    ent[6]  = mk(32'h0040_0000, 20'h00080, 1, 0, 1, 0);
    ent[7]  = mk(32'h0060_0000, 20'h00010, 0, 0, 0, 0);
    ent[11] = mk(32'h0050_0000, 20'h00010, 1, 1, 0, 0);

    // R1 reset state
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk(res_valid_o == 1'b0, "res_valid_o in reset", res_valid_o, 0);
    chk(mem_req_o == 1'b0, "mem_req_o in reset", mem_req_o, 0);
    chk(req_ready_o == 1'b1, "req_ready_o in reset", req_ready_o, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4/R9 legal translations, all access types, varied latency
    send("R4", 0, 32'h00123, 0, 1, 1);
    send("R4", 0, 32'h00FFF, 1, 1, 2);
    send("R9", 0, 32'h00000, 2, 1, 3);
    send("R9", 5, 32'h00020, 0, 1, 2);   // base+off wraps to 0x10
    // R7 permissions
    send("R7", 1, 32'h00010, 1, 1, 1);   // write to read-only
    send("R7", 1, 32'h00010, 0, 1, 1);
    send("R7", 2, 32'h00004, 0, 1, 2);   // read of execute-only
    send("R7", 2, 32'h00004, 2, 1, 1);
    send("R7", 6, 32'h00004, 1, 1, 1);
    send("R7", 0, 32'h00004, 3, 1, 1);   // reserved type
    // R5 invalid
    send("R5", 3, 32'h00001, 0, 1, 1);
    // R6 limit edges
    send("R6", 1, 32'h000FF, 0, 1, 1);
    send("R6", 1, 32'h00100, 0, 1, 1);
    send("R6", 4, 32'h00000, 0, 1, 3);
    // R8 priority
    send("R8", 7, 32'h00050, 3, 1, 1);   // invalid beats limit and perm
    send("R8", 1, 32'h00200, 1, 1, 2);   // limit beats perm
    // R2 range
    send("R2", 12, 32'h00000, 0, 1, 1);
    send("R2", 11, 32'h00004, 0, 1, 1);
    send("R2", 255, 32'h00004, 0, 1, 1);
    send("R2", 20, 32'h00004, 0, 3, 1);  // back-to-back range faults
    cur_tag = "R2";
    seg_count_i = 9'd0;
    send("R2", 0, 32'h00004, 0, 1, 1);
    seg_count_i = 9'd12;
    // R3 held request across busy period, moved table base
    send("R3", 0, 32'h00040, 0, 4, 3);
    tbl_base_i = 32'h0004_0008;
    send("R3", 6, 32'h00010, 1, 1, 2);
    tbl_base_i = 32'h0000_1000;
    // R10 spurious response strobe while idle
    cur_tag = "R10";
    @(negedge clk); spur = 1'b1;
    repeat (4) @(negedge clk);
    send("R10", 0, 32'h00008, 0, 1, 1);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule